// File: doc/BRIEF.md
# General-Purpose I/O Unit with Per-Pin Interrupt Qualification

This block provides 32 bidirectional I/O pins and 18 extra pins that can only drive. Software configures it through a 16-bit register bus. Every 32-bit control register occupies two consecutive word addresses. For each bidirectional pin, software picks the direction and the output value. It also picks how an input condition becomes an interrupt: edge or level, the active level, and whether the status bit latches or tracks the condition.

Each bidirectional input passes through a two-flop synchroniser. The synchronised level feeds the readable pin-level register and the per-pin interrupt logic. Per-pin status bits are masked by the enable register. The masked result leaves the block in two forms: a pending vector for a second-level interrupt controller, and one registered combined interrupt line.

Top module: `gpio_unit`

## Requirements
- R1: After a synchronous reset, the direction, output latch, output-only data, enable, trigger, polarity and hold registers are all zero. `pin_oe`, `pout_only` and `irq` are low.
- R2: The word address is {register index, half}. The index is bits 3:1 and the half is bit 0, where 0 selects bits 15:0 and 1 selects bits 31:16. The indices are: 0 direction, 1 pin data, 2 output-only data, 3 status, 4 enable, 5 trigger, 6 polarity, 7 hold. A write to one half leaves the other half unchanged.
- R3: Direction bit 1 makes the pin an output, and bit 0 makes it an input. `pin_oe` mirrors the direction register, and `pin_out` mirrors the output latch.
- R4: A write to the pin data register (index 1) loads the output latch. A read returns the pin input level after two synchroniser flops.
- R5: Output-only pin k (k = 0..17, the pins numbered 32..49) is driven by bit k of the output-only data register (index 2). Bits 31:18 of that register ignore writes and read as zero.
- R6: In level mode (trigger bit 0), a polarity bit of 1 makes a high input the active condition, and a polarity bit of 0 makes a low input active.
- R7: In edge mode (trigger bit 1), only a rising edge of the synchronised input is an event. The polarity bit has no effect, and a falling edge or a steady level creates no event.
- R8: With the hold bit at 1, the status bit stays set after the condition ends. It clears only when a 1 is written to that status bit, and writing 0 leaves it unchanged.
- R9: With the hold bit at 0, the status bit follows the condition one cycle later. A write of 1 to the status bit does not clear it while the condition persists.
- R10: A pin configured as output never sets its status bit.
- R11: `irq_pending` is status AND enable. `irq` is the OR of `irq_pending`, registered, so it rises one cycle after the status bit.
- R12: When a held status bit is written with 1 in the same cycle that its condition is still present, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address: register index and half select |
| bus_we | input | 1 | Write strobe for one 16-bit word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed word (combinational) |
| pin_in | input | 32 | Input levels of the bidirectional pins |
| pin_out | output | 32 | Output values of the bidirectional pins |
| pin_oe | output | 32 | Output enable per bidirectional pin |
| pout_only | output | 18 | Output-only pins 32..49 |
| irq_pending | output | 32 | Enabled pending status per pin |
| irq | output | 1 | Registered combined interrupt |

## Verification
The bench measures the exact latency from a pin change to the status bit and then to `irq`. A design that skipped a synchroniser stage, or left the combined line unregistered, would assert one cycle early.

It clears a latched bit by writing zero, by writing one while the level condition is still present, and by writing one after the condition has gone. A design with clear priority over set, or with write-zero-clears behaviour, would drop the bit at the wrong moment.

Edge mode is tested with the polarity bit at zero and the pin held low. A design that let polarity leak into edge mode would report a spurious event. A pin switched to output while its input is active must stay silent, so a design that ignored direction would raise status.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int GPIO_NIO   = 32;
    localparam int GPIO_NOUT  = 18;
    localparam int GPIO_HALF  = 16;
    localparam int GPIO_REGW  = 2 * GPIO_HALF;
    localparam int GPIO_AW    = 4;
    localparam int GPIO_SYNC  = 2;
    localparam int GPIO_OHI   = GPIO_NOUT - GPIO_HALF;

    typedef enum logic [2:0] {
        SEL_DIR  = 3'd0,
        SEL_DATA = 3'd1,
        SEL_ODAT = 3'd2,
        SEL_STAT = 3'd3,
        SEL_EN   = 3'd4,
        SEL_TRIG = 3'd5,
        SEL_POL  = 3'd6,
        SEL_HOLD = 3'd7
    } gpio_sel_e;

    typedef struct packed {
        logic [GPIO_NIO-1:0]  dir;
        logic [GPIO_NIO-1:0]  dout;
        logic [GPIO_NIO-1:0]  en;
        logic [GPIO_NIO-1:0]  trig;
        logic [GPIO_NIO-1:0]  pol;
        logic [GPIO_NIO-1:0]  hold;
        logic [GPIO_NOUT-1:0] odat;
    } gpio_cfg_t;

    function automatic logic [GPIO_REGW-1:0] merge_half(
        input logic [GPIO_REGW-1:0] cur,
        input logic [GPIO_HALF-1:0] wd,
        input logic                 hi
    );
        merge_half = hi ? {wd, cur[GPIO_HALF-1:0]}
                        : {cur[GPIO_REGW-1:GPIO_HALF], wd};
    endfunction

    function automatic logic [GPIO_HALF-1:0] pick_half(
        input logic [GPIO_REGW-1:0] v,
        input logic                 hi
    );
        pick_half = hi ? v[GPIO_REGW-1:GPIO_HALF] : v[GPIO_HALF-1:0];
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] dprev
);
    logic [W-1:0] stg [0:STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k <= STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= din;
            for (int k = 1; k <= STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign dout  = stg[STAGES-1];
    assign dprev = stg[STAGES];
endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic lvl_prev,
    input  logic is_in,
    input  logic edge_md,
    input  logic act_hi,
    input  logic hold_md,
    input  logic clr,
    output logic status
);
    logic rise;
    logic cond;

    assign rise = lvl & ~lvl_prev;
    assign cond = is_in & (edge_md ? rise : (act_hi ? lvl : ~lvl));

    always_ff @(posedge clk) begin
        if (rst)          status <= 1'b0;
        else if (hold_md) status <= cond | (status & ~clr);
        else              status <= cond;
    end

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
        (hold_md && status && !clr) |=> status); // R8
    AST_THRU_DROP: assert property (@(posedge clk) disable iff (rst)
        (!hold_md && !cond) |=> !status); // R9
    AST_OUT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (!is_in && !hold_md) |=> !status); // R10
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs import gpio_pkg::*; (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [GPIO_AW-1:0]   addr,
    input  logic                 we,
    input  logic [GPIO_HALF-1:0] wdata,
    input  logic [GPIO_NIO-1:0]  status,
    input  logic [GPIO_NIO-1:0]  pin_lvl,
    output gpio_cfg_t            cfg,
    output logic [GPIO_NIO-1:0]  clr,
    output logic [GPIO_HALF-1:0] rdata
);
    gpio_sel_e sel;
    logic      hi;
    logic [GPIO_REGW-1:0] odat_wide;

    assign sel       = gpio_sel_e'(addr[GPIO_AW-1:1]);
    assign hi        = addr[0];
    assign odat_wide = {{(GPIO_REGW-GPIO_NOUT){1'b0}}, cfg.odat};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            unique case (sel)
                SEL_DIR:  cfg.dir  <= merge_half(cfg.dir,  wdata, hi);
                SEL_DATA: cfg.dout <= merge_half(cfg.dout, wdata, hi);
                SEL_ODAT: begin
                    if (hi) cfg.odat[GPIO_NOUT-1:GPIO_HALF] <= wdata[GPIO_OHI-1:0];
                    else    cfg.odat[GPIO_HALF-1:0]         <= wdata;
                end
                SEL_STAT: ;
                SEL_EN:   cfg.en   <= merge_half(cfg.en,   wdata, hi);
                SEL_TRIG: cfg.trig <= merge_half(cfg.trig, wdata, hi);
                SEL_POL:  cfg.pol  <= merge_half(cfg.pol,  wdata, hi);
                SEL_HOLD: cfg.hold <= merge_half(cfg.hold, wdata, hi);
                default:  ;
            endcase
        end
    end

    always_comb begin
        clr = '0;
        if (we && sel == SEL_STAT)
            clr = hi ? {wdata, {GPIO_HALF{1'b0}}} : {{GPIO_HALF{1'b0}}, wdata};
    end

    always_comb begin
        unique case (sel)
            SEL_DIR:  rdata = pick_half(cfg.dir,  hi);
            SEL_DATA: rdata = pick_half(pin_lvl,  hi);
            SEL_ODAT: rdata = pick_half(odat_wide, hi);
            SEL_STAT: rdata = pick_half(status,   hi);
            SEL_EN:   rdata = pick_half(cfg.en,   hi);
            SEL_TRIG: rdata = pick_half(cfg.trig, hi);
            SEL_POL:  rdata = pick_half(cfg.pol,  hi);
            SEL_HOLD: rdata = pick_half(cfg.hold, hi);
            default:  rdata = '0;
        endcase
    end

    AST_ODAT_UPPER: assert property (@(posedge clk) disable iff (rst)
        (we && sel == SEL_ODAT && hi) |=>
        cfg.odat[GPIO_NOUT-1:GPIO_HALF] == $past(wdata[GPIO_OHI-1:0])); // R5
    AST_HALF_ISOLATE: assert property (@(posedge clk) disable iff (rst)
        (we && sel == SEL_EN && !hi) |=>
        $stable(cfg.en[GPIO_REGW-1:GPIO_HALF])); // R2
endmodule

// File: rtl/gpio_unit.sv
module gpio_unit import gpio_pkg::*; (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [GPIO_AW-1:0]   bus_addr,
    input  logic                 bus_we,
    input  logic [GPIO_HALF-1:0] bus_wdata,
    output logic [GPIO_HALF-1:0] bus_rdata,
    input  logic [GPIO_NIO-1:0]  pin_in,
    output logic [GPIO_NIO-1:0]  pin_out,
    output logic [GPIO_NIO-1:0]  pin_oe,
    output logic [GPIO_NOUT-1:0] pout_only,
    output logic [GPIO_NIO-1:0]  irq_pending,
    output logic                 irq
);
    gpio_cfg_t           cfg;
    logic [GPIO_NIO-1:0] lvl;
    logic [GPIO_NIO-1:0] lvl_prev;
    logic [GPIO_NIO-1:0] status;
    logic [GPIO_NIO-1:0] clr;

    gpio_sync #(.W(GPIO_NIO), .STAGES(GPIO_SYNC)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .din   (pin_in),
        .dout  (lvl),
        .dprev (lvl_prev)
    );

    gpio_regs regs_i (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .status  (status),
        .pin_lvl (lvl),
        .cfg     (cfg),
        .clr     (clr),
        .rdata   (bus_rdata)
    );

    for (genvar i = 0; i < GPIO_NIO; i++) begin : g_pin
        gpio_pin_irq cell_i (
            .clk      (clk),
            .rst      (rst),
            .lvl      (lvl[i]),
            .lvl_prev (lvl_prev[i]),
            .is_in    (~cfg.dir[i]),
            .edge_md  (cfg.trig[i]),
            .act_hi   (cfg.pol[i]),
            .hold_md  (cfg.hold[i]),
            .clr      (clr[i]),
            .status   (status[i])
        );
    end

    assign pin_out     = cfg.dout;
    assign pin_oe      = cfg.dir;
    assign pout_only   = cfg.odat;
    assign irq_pending = status & cfg.en;

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |irq_pending;
    end

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (irq_pending == '0) |=> !irq); // R11
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
        (irq_pending != '0) |=> irq); // R11
endmodule

// File: tb/gpio_unit_tb_top.sv
`timescale 1ns/1ps
module gpio_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bus_addr;
    logic        bus_we;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [31:0] pin_in;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic [17:0] pout_only;
    logic [31:0] irq_pending;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    gpio_unit dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pout_only(pout_only),
        .irq_pending(irq_pending), .irq(irq)
    );

    localparam logic [3:0] A_DIR_LO = 4'd0, A_DIR_HI = 4'd1, A_DAT_LO = 4'd2,
        A_DAT_HI = 4'd3, A_ODT_LO = 4'd4, A_ODT_HI = 4'd5, A_STA_LO = 4'd6,
        A_EN_LO = 4'd8, A_EN_HI = 4'd9, A_TRG_LO = 4'd10, A_POL_LO = 4'd12,
        A_POL_HI = 4'd13, A_HLD_LO = 4'd14;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr16(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd16(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        #1;
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 pout_only", {14'd0, pout_only}, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        rd16(A_EN_LO, v);  chk("R1 enable lo", {16'd0, v}, 0);
        rd16(A_DIR_HI, v); chk("R1 direction hi", {16'd0, v}, 0);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        wr16(A_DIR_LO, 16'h0F0F);
        wr16(A_DIR_HI, 16'hA5A5);
        #1 chk("R3 pin_oe mirrors direction", pin_oe, 32'hA5A5_0F0F);
        wr16(A_DIR_LO, 16'h1234);
        rd16(A_DIR_HI, v); chk("R2 upper half kept", {16'd0, v}, 32'hA5A5);
        rd16(A_DIR_LO, v); chk("R2 lower half read", {16'd0, v}, 32'h1234);
        wr16(A_DAT_LO, 16'h5678);
        wr16(A_DAT_HI, 16'h9ABC);
        #1 chk("R4 data write drives latch", pin_out, 32'h9ABC_5678);
        wr16(A_DIR_LO, 16'h0000);
        wr16(A_DIR_HI, 16'h0000);
    endtask

    task automatic t_input_read();
        logic [15:0] v;
        @(negedge clk) pin_in = 32'hDEAD_BEEF;
        idle(3);
        rd16(A_DAT_LO, v); chk("R4 pin level lo", {16'd0, v}, 32'hBEEF);
        rd16(A_DAT_HI, v); chk("R4 pin level hi", {16'd0, v}, 32'hDEAD);
        @(negedge clk) pin_in = 32'h0;
        idle(4);
    endtask

    task automatic t_outonly();
        logic [15:0] v;
        wr16(A_ODT_LO, 16'h0001);
        #1 chk("R5 bit0 drives pin 32", {14'd0, pout_only}, 32'h1);
        wr16(A_ODT_LO, 16'hFFFF);
        wr16(A_ODT_HI, 16'hFFFF);
        #1 chk("R5 all output-only pins", {14'd0, pout_only}, 32'h3FFFF);
        rd16(A_ODT_HI, v); chk("R5 unused bits read zero", {16'd0, v}, 32'h0003);
    endtask

    task automatic t_level_high();
        logic [15:0] v;
        wr16(A_POL_LO, 16'hFFFF);
        wr16(A_POL_HI, 16'hFFFF);
        wr16(A_EN_LO, 16'h0020);
        idle(3);
        @(negedge clk);
        bus_addr = A_STA_LO;
        pin_in[5] = 1'b1;
        idle(2); #1 chk("R6 status not yet set", {31'd0, bus_rdata[5]}, 0);
        idle(1); #1 chk("R6 active-high status", {31'd0, bus_rdata[5]}, 1);
        chk("R11 irq one cycle after status", {31'd0, irq}, 0);
        idle(1); #1 chk("R11 irq asserted", {31'd0, irq}, 1);
        chk("R11 pending vector", irq_pending, 32'h20);
        wr16(A_STA_LO, 16'h0020);
        rd16(A_STA_LO, v); chk("R9 through clear ignored", {31'd0, v[5]}, 1);
        @(negedge clk) pin_in[5] = 1'b0;
        idle(3); #1 chk("R9 through follows condition", {31'd0, bus_rdata[5]}, 0);
        idle(1); #1 chk("R11 irq drops", {31'd0, irq}, 0);
    endtask

    task automatic t_level_low();
        logic [15:0] v;
        wr16(A_POL_LO, 16'hFFBF);
        idle(3);
        rd16(A_STA_LO, v); chk("R6 active-low with low pin", {31'd0, v[6]}, 1);
        @(negedge clk) pin_in[6] = 1'b1;
        idle(3);
        rd16(A_STA_LO, v); chk("R6 active-low with high pin", {31'd0, v[6]}, 0);
        @(negedge clk) pin_in[6] = 1'b0;
        wr16(A_POL_LO, 16'hFFFF);
        idle(3);
    endtask

    task automatic t_edge_hold();
        logic [15:0] v;
        wr16(A_POL_LO, 16'hFF7F);
        wr16(A_TRG_LO, 16'h0080);
        wr16(A_HLD_LO, 16'h0080);
        idle(3);
        wr16(A_STA_LO, 16'h0080);
        idle(4);
        rd16(A_STA_LO, v); chk("R7 polarity ignored, no event at low level", {31'd0, v[7]}, 0);
        @(negedge clk) pin_in[7] = 1'b1;
        idle(4);
        rd16(A_STA_LO, v); chk("R7 rising edge sets status", {31'd0, v[7]}, 1);
        @(negedge clk) pin_in[7] = 1'b0;
        idle(4);
        rd16(A_STA_LO, v); chk("R8 held after input falls", {31'd0, v[7]}, 1);
        wr16(A_STA_LO, 16'h0000);
        rd16(A_STA_LO, v); chk("R8 write zero keeps status", {31'd0, v[7]}, 1);
        wr16(A_STA_LO, 16'h0080);
        rd16(A_STA_LO, v); chk("R8 write one clears status", {31'd0, v[7]}, 0);
        idle(4);
        rd16(A_STA_LO, v); chk("R7 falling edge no event", {31'd0, v[7]}, 0);
    endtask

    task automatic t_hold_level();
        logic [15:0] v;
        wr16(A_HLD_LO, 16'h0280);
        @(negedge clk) pin_in[9] = 1'b1;
        idle(4);
        rd16(A_STA_LO, v); chk("R8 held level status set", {31'd0, v[9]}, 1);
        wr16(A_STA_LO, 16'h0200);
        rd16(A_STA_LO, v); chk("R12 set wins over clear", {31'd0, v[9]}, 1);
        @(negedge clk) pin_in[9] = 1'b0;
        idle(4);
        rd16(A_STA_LO, v); chk("R8 stays after condition ends", {31'd0, v[9]}, 1);
        wr16(A_STA_LO, 16'h0200);
        rd16(A_STA_LO, v); chk("R8 cleared by write one", {31'd0, v[9]}, 0);
    endtask

    task automatic t_output_pin();
        logic [15:0] v;
        wr16(A_DIR_LO, 16'h0400);
        @(negedge clk) pin_in[10] = 1'b1;
        idle(4);
        rd16(A_STA_LO, v); chk("R10 output pin raises no status", {31'd0, v[10]}, 0);
        #1 chk("R11 disabled pin no pending", irq_pending, 0);
        chk("R11 irq low", {31'd0, irq}, 0);
        wr16(A_DIR_LO, 16'h0000);
        idle(3);
        rd16(A_STA_LO, v); chk("R10 same pin as input sets status", {31'd0, v[10]}, 1);
        #1 chk("R11 status without enable no irq", {31'd0, irq}, 0);
    endtask

    initial begin
        rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
        idle(3);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_regs();
        t_input_read();
        t_outonly();
        t_level_high();
        t_level_low();
        t_edge_hold();
        t_hold_level();
        t_output_pin();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule